// File: doc/BRIEF.md
# USB Device Control and Event Register Bank

This block is a byte-wide register bank that an on-chip microcontroller uses to run the device side of a USB 2.0 link. The firmware reaches three registers through a simple address/data bus with single-cycle read and write strobes. The control register drives the transceiver and FIFO control lines. The event register latches pulses from the USB signalling engine and is cleared by writing ones to it. The third register holds a soft reset for the camera sensor-interface block.

Several control bits are cleared by hardware when the engine reports the matching condition. The end of resume signalling clears high-speed suspend. A transmitted test packet clears test-packet enable. Any event pulse clears power-down. The TX read-pointer reset bit is not stored: a write of 1 to it gives a single-cycle strobe. Out of reset the D+ line is left floating, so the host sees no attach until firmware clears that bit. An interrupt line is high whenever any event bit is set.

Top module: `usb_devreg_bank`

## Requirements
- R1: After reset the control register reads 0x04 (dp_float = 1, every other control output 0), the event register reads 0x00, the sensor-reset register reads 0x00, and irq is 0.
- R2: Control bits 7 (hs_suspend), 6 (chirp_det_en), 5 (test_pkt_en), 2 (dp_float), 1 (susp_det_dis) and 0 (power_down) store the written value and drive the matching output. Bit 3 is reserved and bit 4 is not stored, so both read back as 0.
- R3: A write with control bit 4 set raises txf0_rdptr_rst for exactly the one cycle after the write edge. The other control bits take the written data as usual.
- R4: A resume_end pulse clears hs_suspend. If firmware writes 1 to bit 7 in the same cycle, the hardware clear wins.
- R5: A test_pkt_sent pulse clears test_pkt_en. If firmware writes 1 to bit 5 in the same cycle, the hardware clear wins.
- R6: Any nonzero usb_evt_set pulse clears power_down. If firmware writes 1 to bit 0 in the same cycle, the hardware clear wins.
- R7: Each usb_evt_set bit latches the event-register bit at the same position: 7 chirp detected, 6 SOF, 5 bus reset, 4 wakeup, 3 resume, 2 suspend, 1 EP0 transmit, 0 EP0 receive. The bit holds until it is cleared.
- R8: Writing the event address clears each event bit whose write-data bit is 1 and leaves the other bits unchanged.
- R9: When a set pulse and a write-1-to-clear hit the same event bit in the same cycle, the bit ends up set.
- R10: irq is 1 exactly when at least one event bit is set. It changes at the same edge as the event bits.
- R11: Bit 0 of the sensor-reset register drives sensor_rst while it is 1. Bits 7 to 1 read 0.
- R12: A read of an unmapped address returns 0x00. A write to an unmapped address changes no register.
- R13: bus_rdata is loaded at the edge that samples bus_rd, with the register value held before that edge. It keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (8) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| usb_evt_set | input | 8 | Event set pulses from the USB engine |
| resume_end | input | 1 | End of resume signalling seen (K to SE0) |
| test_pkt_sent | input | 1 | Test packet has been transmitted |
| hs_suspend | output | 1 | High-speed suspend |
| chirp_det_en | output | 1 | Enable for the high-speed chirp detector |
| test_pkt_en | output | 1 | Send an endpoint 1 packet without an IN token |
| txf0_rdptr_rst | output | 1 | One-cycle reset of the TX FIFO0 read pointer |
| dp_float | output | 1 | Leave D+ floating (no attach) |
| susp_det_dis | output | 1 | Disable suspend detection |
| power_down | output | 1 | Power-down request |
| sensor_rst | output | 1 | Soft reset into the sensor interface |
| irq | output | 1 | OR of all event bits |

## Verification
Every result in this block is due one edge after its stimulus. A write or a hardware pulse changes the control outputs, the event bits, sensor_rst, irq and txf0_rdptr_rst at the first rising edge that samples it. The bench drives each access on a falling edge, lets one rising edge pass, and samples on the next falling edge. There it checks the outputs directly, or issues a one-cycle read whose bus_rdata it samples at the following falling edge. The TX strobe is checked high at the first falling edge after the write and low at the next one, which confirms it lasts a single cycle. The collision cases for R4, R5, R6 and R9 drive the write and the hardware pulse in the same cycle. R13 is checked by pairing a read with an event pulse, to show that the read returns the value from before that edge.

// File: rtl/usbreg_pkg.sv
package usbreg_pkg;
  localparam int REG_W = 8;

  // control register bit positions (firmware decodes these)
  localparam int C_HSSUSP  = 7;
  localparam int C_CHIRPEN = 6;
  localparam int C_TSTPK   = 5;
  localparam int C_TXRST   = 4;
  localparam int C_RSV     = 3;
  localparam int C_DPFLOAT = 2;
  localparam int C_SUSDIS  = 1;
  localparam int C_PWRDN   = 0;

  localparam logic [REG_W-1:0] CTRL_RESET = 8'h04;
  // bits that hold state: all but the strobe and the reserved bit
  localparam logic [REG_W-1:0] CTRL_STORE = 8'hE7;

  typedef struct packed {
    logic hs_susp;
    logic chirp_en;
    logic tstpk_en;
    logic txrst;
    logic rsv;
    logic dp_float;
    logic sus_dis;
    logic pwrdn;
  } ctrl_t;
endpackage

// File: rtl/usbreg_ctrl.sv
module usbreg_ctrl
  import usbreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             resume_end,
  input  logic             tstpk_sent,
  input  logic             any_evt,
  output ctrl_t            ctrl_q,
  output logic             txrst_pulse
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = ctrl_t'(wdata & CTRL_STORE);
    // hardware clears are applied last so they win over a firmware write
    if (resume_end) ctrl_d.hs_susp  = 1'b0;
    if (tstpk_sent) ctrl_d.tstpk_en = 1'b0;
    if (any_evt)    ctrl_d.pwrdn    = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= ctrl_t'(CTRL_RESET);
      txrst_pulse <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      txrst_pulse <= wr_en & wdata[C_TXRST];
    end
  end
endmodule

// File: rtl/usbreg_event.sv
module usbreg_event #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_pulse,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] evt_q,
  output logic         irq
);
  logic [W-1:0] evt_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // a set pulse outranks a write-1-to-clear on the same bit
    always_comb begin
      if (set_pulse[i])                 evt_d[i] = 1'b1;
      else if (clr_en && clr_mask[i])   evt_d[i] = 1'b0;
      else                              evt_d[i] = evt_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq   <= 1'b0;
    end else begin
      evt_q <= evt_d;
      irq   <= |evt_d;
    end
  end
endmodule

// File: rtl/usbreg_srst.sv
module usbreg_srst (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wbit,
  output logic srst_q
);
  always_ff @(posedge clk) begin
    if (rst)        srst_q <= 1'b0;
    else if (wr_en) srst_q <= wbit;
  end
endmodule

// File: rtl/usb_devreg_bank.sv
module usb_devreg_bank
  import usbreg_pkg::*;
#(
  parameter int             AW     = 8,
  parameter logic [AW-1:0]  A_CTRL = 8'h20,
  parameter logic [AW-1:0]  A_EVT  = 8'h21,
  parameter logic [AW-1:0]  A_SRST = 8'h08
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [REG_W-1:0] usb_evt_set,
  input  logic             resume_end,
  input  logic             test_pkt_sent,
  output logic             hs_suspend,
  output logic             chirp_det_en,
  output logic             test_pkt_en,
  output logic             txf0_rdptr_rst,
  output logic             dp_float,
  output logic             susp_det_dis,
  output logic             power_down,
  output logic             sensor_rst,
  output logic             irq
);
  logic             wr_ctrl, wr_evt, wr_srst;
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] evt_bits;
  logic             srst_q;
  logic [REG_W-1:0] rd_mux;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_evt  = bus_wr && (bus_addr == A_EVT);
  assign wr_srst = bus_wr && (bus_addr == A_SRST);

  usbreg_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_ctrl),
    .wdata       (bus_wdata),
    .resume_end  (resume_end),
    .tstpk_sent  (test_pkt_sent),
    .any_evt     (|usb_evt_set),
    .ctrl_q      (ctrl_q),
    .txrst_pulse (txf0_rdptr_rst)
  );

  usbreg_event #(.W(REG_W)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (usb_evt_set),
    .clr_en    (wr_evt),
    .clr_mask  (bus_wdata),
    .evt_q     (evt_bits),
    .irq       (irq)
  );

  usbreg_srst u_srst (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_srst),
    .wbit   (bus_wdata[0]),
    .srst_q (srst_q)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CTRL)      rd_mux = REG_W'(ctrl_q) & CTRL_STORE;
    else if (bus_addr == A_EVT)  rd_mux = evt_bits;
    else if (bus_addr == A_SRST) rd_mux = {{(REG_W-1){1'b0}}, srst_q};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign hs_suspend   = ctrl_q.hs_susp;
  assign chirp_det_en = ctrl_q.chirp_en;
  assign test_pkt_en  = ctrl_q.tstpk_en;
  assign dp_float     = ctrl_q.dp_float;
  assign susp_det_dis = ctrl_q.sus_dis;
  assign power_down   = ctrl_q.pwrdn;
  assign sensor_rst   = srst_q;
endmodule

// File: rtl/usbreg_checker.sv
module usbreg_checker #(
  parameter int            AW     = 8,
  parameter logic [AW-1:0] A_CTRL = 8'h20,
  parameter logic [AW-1:0] A_SRST = 8'h08
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_wr,
  input logic [7:0]    usb_evt_set,
  input logic          resume_end,
  input logic          test_pkt_sent,
  input logic          hs_suspend,
  input logic          test_pkt_en,
  input logic          txf0_rdptr_rst,
  input logic          dp_float,
  input logic          power_down,
  input logic          sensor_rst,
  input logic          irq,
  input logic [7:0]    evt_bits
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dp_float && !power_down && !sensor_rst && !irq));

  a_r3_strobe_from_write: assert property (@(posedge clk) disable iff (rst)
    txf0_rdptr_rst |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[4]));

  a_r4_resume_clears: assert property (@(posedge clk) disable iff (rst)
    resume_end |=> !hs_suspend);

  a_r5_sent_clears: assert property (@(posedge clk) disable iff (rst)
    test_pkt_sent |=> !test_pkt_en);

  a_r6_event_wakes: assert property (@(posedge clk) disable iff (rst)
    (usb_evt_set != 8'h00) |=> !power_down);

  a_r9_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (usb_evt_set != 8'h00) |=> ((evt_bits & $past(usb_evt_set)) == $past(usb_evt_set)));

  a_r10_irq_matches: assert property (@(posedge clk) disable iff (rst)
    irq == (evt_bits != 8'h00));

  a_r11_srst_holds: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == A_SRST) |=> $stable(sensor_rst));
endmodule

bind usb_devreg_bank usbreg_checker #(.AW(AW), .A_CTRL(A_CTRL), .A_SRST(A_SRST)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .bus_wr         (bus_wr),
  .usb_evt_set    (usb_evt_set),
  .resume_end     (resume_end),
  .test_pkt_sent  (test_pkt_sent),
  .hs_suspend     (hs_suspend),
  .test_pkt_en    (test_pkt_en),
  .txf0_rdptr_rst (txf0_rdptr_rst),
  .dp_float       (dp_float),
  .power_down     (power_down),
  .sensor_rst     (sensor_rst),
  .irq            (irq),
  .evt_bits       (evt_bits)
);

// File: tb/usb_devreg_bank_bench.sv
`timescale 1ns/1ps
module usb_devreg_bank_bench;
  localparam logic [7:0] A_CTRL = 8'h20;
  localparam logic [7:0] A_EVT  = 8'h21;
  localparam logic [7:0] A_SRST = 8'h08;
  localparam logic [7:0] A_NONE = 8'h7F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0, bus_wdata = '0, usb_evt_set = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, resume_end = 1'b0, test_pkt_sent = 1'b0;
  logic [7:0] bus_rdata;
  logic hs_suspend, chirp_det_en, test_pkt_en, txf0_rdptr_rst, dp_float;
  logic susp_det_dis, power_down, sensor_rst, irq;

  int n_pass = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  usb_devreg_bank u_usb_devreg_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .usb_evt_set(usb_evt_set), .resume_end(resume_end), .test_pkt_sent(test_pkt_sent),
    .hs_suspend(hs_suspend), .chirp_det_en(chirp_det_en), .test_pkt_en(test_pkt_en),
    .txf0_rdptr_rst(txf0_rdptr_rst), .dp_float(dp_float), .susp_det_dis(susp_det_dis),
    .power_down(power_down), .sensor_rst(sensor_rst), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    if (act === exp) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one bus cycle from a falling edge to the next; results visible on return
  task automatic step(logic wr, logic rd, logic [7:0] a, logic [7:0] d,
                      logic [7:0] ev, logic re, logic ts);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    usb_evt_set = ev; resume_end = re; test_pkt_sent = ts;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; usb_evt_set = '0; resume_end = 1'b0; test_pkt_sent = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    step(1'b1, 1'b0, a, d, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    step(1'b0, 1'b1, a, 8'h00, 8'h00, 1'b0, 1'b0);
    v = bus_rdata;
  endtask

  task automatic t_reset;
    chk("R1 dp_float", dp_float, 1);
    chk("R1 outputs", {hs_suspend, chirp_det_en, test_pkt_en, txf0_rdptr_rst,
                       susp_det_dis, power_down, sensor_rst, irq}, 0);
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 8'h04);
    rd(A_EVT, rv);  chk("R1 evt", rv, 8'h00);
    rd(A_SRST, rv); chk("R1 srst", rv, 8'h00);
  endtask

  task automatic t_ctrl_rw;
    wr(A_CTRL, 8'hFF);
    chk("R2 outputs set", {hs_suspend, chirp_det_en, test_pkt_en, dp_float,
                           susp_det_dis, power_down}, 8'h3F);
    step(1'b0, 1'b1, A_CTRL, 8'h00, 8'h00, 1'b0, 1'b0); rv = bus_rdata;
    chk("R2 readback masks bits 4,3", rv, 8'hE7);
    wr(A_CTRL, 8'h00);
    chk("R2 outputs clear", {hs_suspend, chirp_det_en, test_pkt_en, dp_float,
                             susp_det_dis, power_down}, 8'h00);
    rd(A_CTRL, rv); chk("R2 readback zero", rv, 8'h00);
  endtask

  task automatic t_txrst;
    wr(A_CTRL, 8'h10);
    chk("R3 strobe high", txf0_rdptr_rst, 1);
    @(negedge clk);
    chk("R3 strobe one cycle", txf0_rdptr_rst, 0);
    rd(A_CTRL, rv); chk("R3 bit reads 0", rv, 8'h00);
  endtask

  task automatic t_hs;
    wr(A_CTRL, 8'h80); chk("R4 set", hs_suspend, 1);
    step(1'b0, 1'b0, A_CTRL, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R4 resume clears", hs_suspend, 0);
    step(1'b1, 1'b0, A_CTRL, 8'h80, 8'h00, 1'b1, 1'b0);
    chk("R4 hw clear wins", hs_suspend, 0);
  endtask

  task automatic t_tstpk;
    wr(A_CTRL, 8'h20); chk("R5 set", test_pkt_en, 1);
    step(1'b0, 1'b0, A_CTRL, 8'h00, 8'h00, 1'b0, 1'b1);
    chk("R5 sent clears", test_pkt_en, 0);
    step(1'b1, 1'b0, A_CTRL, 8'h20, 8'h00, 1'b0, 1'b1);
    chk("R5 hw clear wins", test_pkt_en, 0);
  endtask

  task automatic t_pwrdn;
    wr(A_CTRL, 8'h01); chk("R6 set", power_down, 1);
    step(1'b0, 1'b0, A_CTRL, 8'h00, 8'h02, 1'b0, 1'b0);
    chk("R6 event clears", power_down, 0);
    step(1'b1, 1'b0, A_CTRL, 8'h01, 8'h40, 1'b0, 1'b0);
    chk("R6 hw clear wins", power_down, 0);
    wr(A_EVT, 8'hFF);
    rd(A_EVT, rv); chk("R8 clear all", rv, 8'h00);
  endtask

  task automatic t_events;
    step(1'b0, 1'b0, A_EVT, 8'h00, 8'hA5, 1'b0, 1'b0);
    chk("R10 irq set", irq, 1);
    rd(A_EVT, rv); chk("R7 latch A5", rv, 8'hA5);
    step(1'b0, 1'b0, A_EVT, 8'h00, 8'h5A, 1'b0, 1'b0);
    rd(A_EVT, rv); chk("R7 accumulate", rv, 8'hFF);
    wr(A_EVT, 8'h0F); rd(A_EVT, rv); chk("R8 partial clear", rv, 8'hF0);
    wr(A_EVT, 8'h00); rd(A_EVT, rv); chk("R8 zero no effect", rv, 8'hF0);
    chk("R10 irq held", irq, 1);
    wr(A_EVT, 8'hF0);
    chk("R10 irq drops", irq, 0);
    rd(A_EVT, rv); chk("R8 cleared", rv, 8'h00);
  endtask

  task automatic t_collide;
    step(1'b1, 1'b0, A_EVT, 8'h01, 8'h01, 1'b0, 1'b0);
    rd(A_EVT, rv); chk("R9 set wins", rv, 8'h01);
    wr(A_EVT, 8'h01); rd(A_EVT, rv); chk("R9 later clear", rv, 8'h00);
  endtask

  task automatic t_srst;
    wr(A_SRST, 8'hFF); chk("R11 reset on", sensor_rst, 1);
    rd(A_SRST, rv); chk("R11 readback", rv, 8'h01);
    wr(A_SRST, 8'h00); chk("R11 reset off", sensor_rst, 0);
  endtask

  task automatic t_unmapped;
    wr(A_CTRL, 8'h42);
    wr(A_NONE, 8'hFF);
    rd(A_CTRL, rv); chk("R12 ctrl untouched", rv, 8'h42);
    chk("R12 srst untouched", sensor_rst, 0);
    rd(A_EVT, rv);  chk("R12 evt untouched", rv, 8'h00);
    rd(A_NONE, rv); chk("R12 unmapped reads 0", rv, 8'h00);
  endtask

  task automatic t_rdtime;
    step(1'b0, 1'b1, A_EVT, 8'h00, 8'h08, 1'b0, 1'b0);
    chk("R13 pre-edge value", bus_rdata, 8'h00);
    @(negedge clk);
    chk("R13 holds without read", bus_rdata, 8'h00);
    rd(A_EVT, rv); chk("R13 next read", rv, 8'h08);
    wr(A_EVT, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset; t_ctrl_rw; t_txrst; t_hs; t_tstpk; t_pwrdn;
    t_events; t_collide; t_srst; t_unmapped; t_rdtime;
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=done");
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end
endmodule